// File: doc/BRIEF.md
# Dynamic Stream-Link Read Unit

This execution unit carries out a "get from stream" operation for a processor pipeline. A command arrives with a runtime link index and a set of flag bits. The unit picks one of up to sixteen AXI4-Stream slave links and returns that link's data word on a register writeback port. It also keeps a two-bit stream status: a carry bit that reports an invalid non-blocking read, and a sticky protocol-error bit.

The pipeline holds the command on the inputs for as long as `stall_o` is high. The flag bits select these behaviours:
- blocking or non-blocking read;
- data or control expectation, checked against TLAST;
- a trap on a TLAST mismatch;
- peek mode, where the word is not consumed;
- atomic mode, which masks external interrupts up to the next read.

A blocking read that is stalled and not atomic can be abandoned when an interrupt arrives. A parameter adds one cycle of latency for an area-lean build. Instruction decode, the pipeline and the trap handler are outside this block.

Top module: `stream_get_unit`

## Requirements
- R1: The link index is `cmd_idx_i` (four bits). Any index greater than or equal to `NUM_LINKS` selects link 0.
- R2: `s_tready_o[k]` is high for exactly one cycle, on the selected link only, in the cycle where that link's TVALID is high and the read completes outside peek mode. The TREADY of every other link stays low.
- R3: A blocking read (`cmd_nb_i`=0) holds `stall_o` high, and every TREADY low, in each cycle where the command is present and the selected TVALID is low.
- R4: A non-blocking read (`cmd_nb_i`=1) never stalls. On completion it sets `sts_carry_o` to 1 if TVALID was low and to 0 if TVALID was high. Blocking reads leave `sts_carry_o` unchanged.
- R5: When TVALID is high on completion and TLAST differs from `cmd_ctrl_i`, the unit sets `sts_err_o`. The bit stays 1 until reset. A matching read leaves it unchanged.
- R6: A mismatch with `cmd_exc_i`=1 raises `exc_o` for one cycle, with `exc_cause_o`=24, and suppresses `wb_en_o` in that cycle.
- R7: With `AREA_OPT`=0, a read that completes in cycle T gives `done_o`=1, `wb_en_o`=1 and `wb_data_o` equal to the link word in cycle T+1, for one cycle only.
- R8: In peek mode (`cmd_test_i`=1), TREADY stays low and the writeback still carries the word.
- R9: `irq_mask_o` is high while an atomic command is present. It stays high from the completion of that command until the next read completes. A non-atomic completion clears it.
- R10: A stalled blocking, non-atomic read with `irq_i`=1 and no mask active is abandoned:
  - `stall_o` drops in that cycle and TREADY stays low;
  - `irq_take_o` pulses in the next cycle, with no `done_o` and no `wb_en_o`.

  If TVALID rises in the same cycle as `irq_i`, the read completes instead.
- R11: With `AREA_OPT`=1, `stall_o` is high in the first cycle of every command. The read completes one cycle later than in the default build.
- R12: After reset, all pulse outputs, both status bits, `irq_mask_o`, `stall_o` and all TREADY outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present, held while stalled |
| cmd_idx_i | input | 4 | Runtime link index |
| cmd_nb_i | input | 1 | Non-blocking read |
| cmd_ctrl_i | input | 1 | Expected TLAST value |
| cmd_exc_i | input | 1 | Trap on TLAST mismatch |
| cmd_test_i | input | 1 | Peek without consuming |
| cmd_atomic_i | input | 1 | Mask interrupts up to the next read |
| irq_i | input | 1 | Pending external interrupt |
| s_tdata_i | input | LW*DATA_W | Packed link data, link k at bits [k*DATA_W +: DATA_W] |
| s_tvalid_i | input | LW | Per-link TVALID |
| s_tlast_i | input | LW | Per-link TLAST |
| s_tready_o | output | LW | Per-link TREADY |
| wb_en_o | output | 1 | Destination write enable |
| wb_data_o | output | DATA_W | Destination write data |
| done_o | output | 1 | Read completed |
| stall_o | output | 1 | Hold the pipeline |
| exc_o | output | 1 | Exception request |
| exc_cause_o | output | 5 | Exception cause code |
| irq_mask_o | output | 1 | Block external interrupts |
| irq_take_o | output | 1 | Stalled read abandoned for an interrupt |
| sts_carry_o | output | 1 | Status carry (invalid non-blocking read) |
| sts_err_o | output | 1 | Sticky TLAST mismatch flag |

## Verification
Two functions can fall in the same cycle:
- A trapping mismatch sets the sticky error bit in the same cycle as the exception pulse, and the bench checks both together with the missing writeback.
- An interrupt and the arrival of TVALID can meet in one cycle while a blocking read is stalled. The bench raises both at the same falling edge and expects a normal completion with TREADY and no abandon pulse.

A separate case checks that an interrupt during a read following an atomic one cannot abandon it.

// File: rtl/stream_get_pkg.sv
package stream_get_pkg;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_STREAM = CAUSE_W'(24);
endpackage

// File: rtl/stream_get_link_sel.sv
module stream_get_link_sel
  import stream_get_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LW        = 4
) (
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [LW*DATA_W-1:0] tdata_i,
  input  logic [LW-1:0]        tvalid_i,
  input  logic [LW-1:0]        tlast_i,
  input  logic                 take_i,
  output logic [DATA_W-1:0]    data_o,
  output logic                 valid_o,
  output logic                 last_o,
  output logic [LW-1:0]        tready_o
);
  logic [IDX_W-1:0] sel;

  // out-of-range index falls back to link 0
  always_comb sel = (int'(idx_i) < int'(NUM_LINKS)) ? idx_i : '0;

  always_comb begin
    data_o  = '0;
    valid_o = 1'b0;
    last_o  = 1'b0;
    for (int i = 0; i < int'(LW); i++) begin
      if (sel == IDX_W'(i)) begin
        data_o  = tdata_i[i*DATA_W +: DATA_W];
        valid_o = tvalid_i[i] && (NUM_LINKS > 0);
        last_o  = tlast_i[i];
      end
    end
  end

  for (genvar g = 0; g < LW; g++) begin : g_rdy
    assign tready_o[g] = take_i && (sel == IDX_W'(g));
  end
endmodule

// File: rtl/stream_get_ctrl.sv
module stream_get_ctrl #(
  parameter bit AREA_OPT = 1'b0,
  parameter bit EXT_EN   = 1'b1,
  parameter bit ENABLE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic nb_i,
  input  logic atomic_i,
  input  logic irq_i,
  input  logic mask_q_i,
  input  logic link_valid_i,
  output logic fire_o,
  output logic abort_o,
  output logic stall_o
);
  logic armed_q;
  logic eval;
  logic cmd;

  assign cmd  = cmd_valid_i && ENABLE;
  // area build spends one cycle arming before it evaluates
  assign eval = cmd && (armed_q || !AREA_OPT);

  assign fire_o  = eval && (link_valid_i || nb_i);
  assign abort_o = EXT_EN && eval && !nb_i && !link_valid_i && irq_i
                   && !atomic_i && !mask_q_i;
  assign stall_o = cmd && !fire_o && !abort_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= cmd && !fire_o && !abort_o;
  end
endmodule

// File: rtl/stream_get_status.sv
module stream_get_status
  import stream_get_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               abort_i,
  input  logic               nb_i,
  input  logic               ctrl_i,
  input  logic               exc_en_i,
  input  logic               atomic_i,
  input  logic               valid_i,
  input  logic               last_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               wb_en_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic               done_o,
  output logic               exc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               carry_o,
  output logic               err_o,
  output logic               mask_q_o,
  output logic               irq_take_o
);
  logic mismatch;
  logic trap;

  assign mismatch = fire_i && valid_i && (last_i != ctrl_i);
  assign trap     = mismatch && exc_en_i;
  assign cause_o  = exc_o ? CAUSE_STREAM : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o    <= 1'b0;
      wb_data_o  <= '0;
      done_o     <= 1'b0;
      exc_o      <= 1'b0;
      carry_o    <= 1'b0;
      err_o      <= 1'b0;
      mask_q_o   <= 1'b0;
      irq_take_o <= 1'b0;
    end else begin
      wb_en_o    <= fire_i && !trap;
      done_o     <= fire_i;
      exc_o      <= trap;
      irq_take_o <= abort_i;
      if (fire_i) wb_data_o <= data_i;
      if (fire_i && nb_i) carry_o <= !valid_i;
      if (mismatch) err_o <= 1'b1;
      if (fire_i || abort_i) mask_q_o <= fire_i && atomic_i;
    end
  end
endmodule

// File: rtl/stream_get_unit.sv
module stream_get_unit
  import stream_get_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter bit          EXC_EN    = 1'b1,
  parameter bit          EXT_EN    = 1'b1,
  parameter bit          AREA_OPT  = 1'b0,
  localparam int unsigned LW       = (NUM_LINKS > 0) ? NUM_LINKS : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [IDX_W-1:0]   cmd_idx_i,
  input  logic               cmd_nb_i,
  input  logic               cmd_ctrl_i,
  input  logic               cmd_exc_i,
  input  logic               cmd_test_i,
  input  logic               cmd_atomic_i,
  input  logic               irq_i,
  input  logic [LW*DATA_W-1:0] s_tdata_i,
  input  logic [LW-1:0]      s_tvalid_i,
  input  logic [LW-1:0]      s_tlast_i,
  output logic [LW-1:0]      s_tready_o,
  output logic               wb_en_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic               done_o,
  output logic               stall_o,
  output logic               exc_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic               irq_mask_o,
  output logic               irq_take_o,
  output logic               sts_carry_o,
  output logic               sts_err_o
);
  localparam bit ENABLE = (NUM_LINKS > 0);

  logic              exc_eff, test_eff, atomic_eff;
  logic              fire, abort, take, mask_q;
  logic              sel_valid, sel_last;
  logic [DATA_W-1:0] sel_data;

  // extended variants collapse to plain reads when not configured
  assign exc_eff    = EXT_EN && EXC_EN && cmd_exc_i;
  assign test_eff   = EXT_EN && cmd_test_i;
  assign atomic_eff = EXT_EN && cmd_atomic_i;
  assign take       = fire && sel_valid && !test_eff;

  stream_get_link_sel #(
    .NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .LW(LW)
  ) u_sel (
    .idx_i   (cmd_idx_i),
    .tdata_i (s_tdata_i),
    .tvalid_i(s_tvalid_i),
    .tlast_i (s_tlast_i),
    .take_i  (take),
    .data_o  (sel_data),
    .valid_o (sel_valid),
    .last_o  (sel_last),
    .tready_o(s_tready_o)
  );

  stream_get_ctrl #(
    .AREA_OPT(AREA_OPT), .EXT_EN(EXT_EN), .ENABLE(ENABLE)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .nb_i        (cmd_nb_i),
    .atomic_i    (atomic_eff),
    .irq_i       (irq_i),
    .mask_q_i    (mask_q),
    .link_valid_i(sel_valid),
    .fire_o      (fire),
    .abort_o     (abort),
    .stall_o     (stall_o)
  );

  stream_get_status #(.DATA_W(DATA_W)) u_sts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .abort_i   (abort),
    .nb_i      (cmd_nb_i),
    .ctrl_i    (cmd_ctrl_i),
    .exc_en_i  (exc_eff),
    .atomic_i  (atomic_eff),
    .valid_i   (sel_valid),
    .last_i    (sel_last),
    .data_i    (sel_data),
    .wb_en_o   (wb_en_o),
    .wb_data_o (wb_data_o),
    .done_o    (done_o),
    .exc_o     (exc_o),
    .cause_o   (exc_cause_o),
    .carry_o   (sts_carry_o),
    .err_o     (sts_err_o),
    .mask_q_o  (mask_q),
    .irq_take_o(irq_take_o)
  );

  assign irq_mask_o = mask_q || (cmd_valid_i && atomic_eff && ENABLE);
endmodule

// File: rtl/stream_get_unit_chk.sv
module stream_get_unit_chk #(
  parameter int unsigned LW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [LW-1:0] s_tvalid_i,
  input logic [LW-1:0] s_tready_o,
  input logic          wb_en_o,
  input logic          done_o,
  input logic          stall_o,
  input logic          exc_o,
  input logic [4:0]    exc_cause_o,
  input logic          irq_mask_o,
  input logic          irq_take_o,
  input logic          sts_err_o
);
  // R2
  tready_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_tready_o));
  // R2
  tready_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_tready_o & ~s_tvalid_i) == '0);
  // R3
  stall_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (cmd_valid_i && s_tready_o == '0));
  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_err_o |=> sts_err_o);
  // R6
  exc_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (!wb_en_o && done_o && exc_cause_o == 5'd24));
  // R7
  done_after_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmd_valid_i));
  // R10
  take_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (!done_o && !wb_en_o && !$past(irq_mask_o)));
endmodule

bind stream_get_unit stream_get_unit_chk #(.LW(LW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .s_tvalid_i (s_tvalid_i),
  .s_tready_o (s_tready_o),
  .wb_en_o    (wb_en_o),
  .done_o     (done_o),
  .stall_o    (stall_o),
  .exc_o      (exc_o),
  .exc_cause_o(exc_cause_o),
  .irq_mask_o (irq_mask_o),
  .irq_take_o (irq_take_o),
  .sts_err_o  (sts_err_o)
);

// File: tb/stream_get_unit_tb_top.sv
`timescale 1ns/1ps
module stream_get_unit_tb_top;
  localparam int NL = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_nb = 0, cmd_ctrl = 0, cmd_exc = 0, cmd_test = 0, cmd_atomic = 0;
  logic [3:0] cmd_idx = '0;
  logic irq = 0;
  logic [NL*DW-1:0] tdata;
  logic [NL-1:0] tvalid = '0, tlast = '0;

  logic [NL-1:0] tready, tready_s;
  logic wb_en, done, stall, exc, mask, take, carry, err;
  logic [DW-1:0] wb_data;
  logic [4:0] cause;
  logic wb_en_s, done_s, stall_s, exc_s, mask_s, take_s, carry_s, err_s;
  logic [DW-1:0] wb_data_s;
  logic [4:0] cause_s;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  stream_get_unit #(.NUM_LINKS(NL), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_idx_i(cmd_idx),
    .cmd_nb_i(cmd_nb), .cmd_ctrl_i(cmd_ctrl), .cmd_exc_i(cmd_exc),
    .cmd_test_i(cmd_test), .cmd_atomic_i(cmd_atomic), .irq_i(irq),
    .s_tdata_i(tdata), .s_tvalid_i(tvalid), .s_tlast_i(tlast), .s_tready_o(tready),
    .wb_en_o(wb_en), .wb_data_o(wb_data), .done_o(done), .stall_o(stall),
    .exc_o(exc), .exc_cause_o(cause), .irq_mask_o(mask), .irq_take_o(take),
    .sts_carry_o(carry), .sts_err_o(err));

  stream_get_unit #(.NUM_LINKS(NL), .DATA_W(DW), .AREA_OPT(1'b1)) dut_slow_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_idx_i(cmd_idx),
    .cmd_nb_i(cmd_nb), .cmd_ctrl_i(cmd_ctrl), .cmd_exc_i(cmd_exc),
    .cmd_test_i(cmd_test), .cmd_atomic_i(cmd_atomic), .irq_i(irq),
    .s_tdata_i(tdata), .s_tvalid_i(tvalid), .s_tlast_i(tlast), .s_tready_o(tready_s),
    .wb_en_o(wb_en_s), .wb_data_o(wb_data_s), .done_o(done_s), .stall_o(stall_s),
    .exc_o(exc_s), .exc_cause_o(cause_s), .irq_mask_o(mask_s), .irq_take_o(take_s),
    .sts_carry_o(carry_s), .sts_err_o(err_s));

  function automatic logic [DW-1:0] word(int k);
    return 32'hC0DE_0000 + 32'(k * 17 + 3);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns later
  task automatic issue(int idx, bit nb, bit ctrl, bit ex, bit tst, bit atm);
    @(negedge clk);
    cmd_idx = 4'(idx); cmd_nb = nb; cmd_ctrl = ctrl; cmd_exc = ex;
    cmd_test = tst; cmd_atomic = atm; cmd_valid = 1'b1;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic release_cmd();
    @(negedge clk);
    cmd_valid = 0; cmd_nb = 0; cmd_ctrl = 0; cmd_exc = 0; cmd_test = 0; cmd_atomic = 0;
    #1;
  endtask

  task automatic t_reset();
    chk("R12 stall", stall, 0);
    chk("R12 tready", tready, 0);
    chk("R12 pulses", {wb_en, done, exc, take}, 0);
    chk("R12 status", {carry, err, mask}, 0);
  endtask

  task automatic t_basic();
    tvalid = 4'b0100; tlast = '0;
    issue(2, 0, 0, 0, 0, 0);
    chk("R3 no stall when valid", stall, 0);
    chk("R2 tready on link 2", tready, 4'b0100);
    after_edge();
    chk("R7 done", done, 1);
    chk("R7 wb_en", wb_en, 1);
    chk("R7 wb_data", wb_data, word(2));
    release_cmd();
    after_edge();
    chk("R7 single pulse", {done, wb_en}, 0);
    chk("R5 match keeps err", err, 0);
  endtask

  task automatic t_ctrl_match();
    tvalid = 4'b1000; tlast = 4'b1000;
    issue(3, 0, 1, 1, 0, 0);
    after_edge();
    chk("R5 control match no err", err, 0);
    chk("R6 no exc on match", exc, 0);
    chk("R7 ctrl word", wb_data, word(3));
    release_cmd();
  endtask

  task automatic t_fallback();
    tvalid = 4'b1111; tlast = '0;
    issue(9, 0, 0, 0, 0, 0);
    chk("R1 idx 9 tready link 0", tready, 4'b0001);
    after_edge();
    chk("R1 idx 9 data", wb_data, word(0));
    release_cmd();
    issue(4, 0, 0, 0, 0, 0);
    chk("R1 idx 4 tready link 0", tready, 4'b0001);
    release_cmd();
    issue(3, 0, 0, 0, 0, 0);
    chk("R1 idx 3 in range", tready, 4'b1000);
    release_cmd();
  endtask

  task automatic t_block();
    tvalid = 4'b1101;
    issue(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R3 stall while invalid", stall, 1);
      chk("R3 tready low while stalled", tready, 0);
      after_edge();
      chk("R3 no done while stalled", done, 0);
      @(negedge clk); #1;
    end
    tvalid[1] = 1'b1;
    #0.5;
    chk("R3 stall released", stall, 0);
    chk("R2 tready link 1", tready, 4'b0010);
    after_edge();
    chk("R3 completes", {done, wb_en}, 2'b11);
    chk("R3 data", wb_data, word(1));
    release_cmd();
  endtask

  task automatic t_nb();
    tvalid = 4'b1101;
    issue(1, 1, 0, 0, 0, 0);
    chk("R4 nb no stall", stall, 0);
    chk("R4 nb invalid no tready", tready, 0);
    after_edge();
    chk("R4 carry set on invalid", carry, 1);
    chk("R4 done", done, 1);
    release_cmd();
    issue(0, 0, 0, 0, 0, 0);
    after_edge();
    chk("R4 blocking keeps carry", carry, 1);
    release_cmd();
    issue(2, 1, 0, 0, 0, 0);
    chk("R4 nb valid tready", tready, 4'b0100);
    after_edge();
    chk("R4 carry cleared on valid", carry, 0);
    release_cmd();
  endtask

  task automatic t_test();
    tvalid = 4'b0001;
    issue(0, 0, 0, 0, 1, 0);
    chk("R8 peek no tready", tready, 0);
    chk("R8 peek no stall", stall, 0);
    after_edge();
    chk("R8 peek writes", {wb_en, done}, 2'b11);
    chk("R8 peek data", wb_data, word(0));
    release_cmd();
  endtask

  task automatic t_mismatch();
    tvalid = 4'b0010; tlast = 4'b0010;
    issue(1, 0, 0, 0, 0, 0);
    after_edge();
    chk("R5 mismatch sets err", err, 1);
    chk("R6 no exc without flag", exc, 0);
    chk("R5 write still done", wb_en, 1);
    release_cmd();
    tlast = 4'b0000;
    issue(1, 0, 1, 1, 0, 0);
    after_edge();
    chk("R6 exc pulse", exc, 1);
    chk("R6 cause 24", cause, 5'd24);
    chk("R6 wb suppressed", wb_en, 0);
    chk("R5 err with exc same cycle", err, 1);
    release_cmd();
    after_edge();
    chk("R6 exc one cycle", exc, 0);
    chk("R5 err sticky", err, 1);
  endtask

  task automatic t_atomic();
    tvalid = 4'b0001; tlast = '0;
    issue(0, 0, 0, 0, 0, 1);
    chk("R9 mask during atomic", mask, 1);
    after_edge();
    chk("R9 mask after atomic", mask, 1);
    release_cmd();
    tvalid = '0;
    irq = 1'b1;
    issue(2, 0, 0, 0, 0, 0);
    chk("R10 masked irq keeps stall", stall, 1);
    after_edge();
    chk("R10 masked no take", take, 0);
    chk("R9 mask held while stalled", mask, 1);
    @(negedge clk);
    tvalid = 4'b0100; irq = 1'b0;
    after_edge();
    chk("R9 next read completes", done, 1);
    chk("R9 mask cleared", mask, 0);
    release_cmd();
  endtask

  task automatic t_irq();
    tvalid = '0;
    issue(3, 0, 0, 0, 0, 0);
    chk("R10 stalled before irq", stall, 1);
    @(negedge clk);
    irq = 1'b1;
    #1;
    chk("R10 stall drops on irq", stall, 0);
    chk("R10 no tready on abort", tready, 0);
    after_edge();
    chk("R10 take pulse", take, 1);
    chk("R10 no done/wb", {done, wb_en}, 0);
    release_cmd();
    irq = 1'b0;
    issue(3, 0, 0, 0, 0, 0);
    chk("R10 stall again", stall, 1);
    @(negedge clk);
    irq = 1'b1; tvalid = 4'b1000;
    #1;
    chk("R10 data wins tready", tready, 4'b1000);
    after_edge();
    chk("R10 data wins done", {done, take}, 2'b10);
    release_cmd();
    irq = 1'b0;
  endtask

  task automatic t_slow();
    tvalid = 4'b0001; tlast = '0;
    issue(0, 0, 0, 0, 0, 0);
    chk("R11 slow first-cycle stall", stall_s, 1);
    chk("R11 slow no early tready", tready_s, 0);
    after_edge();
    chk("R11 slow not yet done", done_s, 0);
    chk("R11 slow stall released", stall_s, 0);
    chk("R11 slow tready second cycle", tready_s, 4'b0001);
    after_edge();
    chk("R11 slow done", done_s, 1);
    chk("R11 slow data", wb_data_s, word(0));
    release_cmd();
  endtask

  initial begin
    for (int k = 0; k < NL; k++) tdata[k*DW +: DW] = word(k);
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_ctrl_match();
    t_fallback();
    t_block();
    t_nb();
    t_test();
    t_mismatch();
    t_atomic();
    t_irq();
    t_slow();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule